// File: doc/BRIEF.md
# Power-On Reset Time-Out Sequencer

This block produces the internal reset that holds a processor core until supply and clock are usable. It waits for the power-on-reset pulse to end and then runs a fixed power-up delay counted in ticks of the slow internal RC clock. Depending on a static oscillator-mode code, it then counts oscillator periods so the crystal can settle, and it adds a PLL lock wait when the PLL mode is selected. On wake from a power-managed mode only the oscillator-dependent stages are repeated. The external master-clear pin can hold the core in reset at any time. Holding it low does not pause the power-up delay, so releasing the pin after that delay has expired frees the core at once.

The block runs on one system clock. The RC and oscillator clocks arrive as single-cycle enable ticks. The POR and master-clear inputs are asynchronous and pass through a two-flop synchronizer. A one-cycle configuration-reload strobe accompanies every hard or power reset: POR, master-clear, and the core's own reset events (reset instruction, watchdog, stack fault). A stage code is brought out so the sequence can be observed.

Top module: `por_timeout_seq`

## Requirements
- R1: While `rst_n` is low, `core_rst` is 1, `cfg_reload` is 0 and `stage` is 0.
- R2: `stage` is 0 (POR wait) while the synchronized POR input is high, whatever RC ticks arrive. Once POR has been low for two clocks, `stage` becomes 1 (power-up timer).
- R3: The power-up timer stage lasts exactly `PWRT_TICKS` RC ticks, and `core_rst` is 1 throughout it.
- R4: With `osc_mode` 0 (PLL) or 1 (crystal/resonator), the power-up timer is followed by `stage` 2, the oscillator start-up stage, which lasts exactly `OST_CYCLES` oscillator ticks. After it, mode 1 goes to `stage` 4 (running).
- R5: With `osc_mode` 0, the start-up stage is followed by `stage` 3, the PLL lock wait, which lasts exactly `PLL_TICKS` RC ticks and then goes to `stage` 4.
- R6: With `osc_mode` 2 (external clock), 3 (RC), 4 (internal oscillator) or any code from 5 to 7, `stage` goes from 1 directly to 4.
- R7: `core_rst` is 1 while the synchronized `mclr_n` is low, even in `stage` 4. The power-up timer keeps counting meanwhile. After the timer has expired, `core_rst` falls on the third clock after `mclr_n` rises.
- R8: POR asserted in any stage returns `stage` to 0 and clears the stage counter, so the next power-up timer again needs a full `PWRT_TICKS` ticks.
- R9: A `pm_wake` pulse in `stage` 4 with mode 0 or 1 moves to `stage` 2 and raises `core_rst`, then runs the start-up stage (plus the PLL lock wait in mode 0) without the power-up timer. With modes 2 to 7, a wake pulse leaves `stage` at 4 and `core_rst` at 0.
- R10: `cfg_reload` pulses for one clock when POR rises, when synchronized master-clear falls, and on `hard_rst_evt`. It does not pulse on `pm_wake`.
- R11: A one-cycle `hard_rst_evt` in `stage` 4 sets `core_rst` and `cfg_reload` to 1 for the following clock only.
- R12: `stage` encodes 0 POR wait, 1 power-up timer, 2 oscillator start-up, 3 PLL lock, 4 running. No other value occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer registers |
| por_in | input | 1 | Asynchronous power-on/brown-out reset pulse, active high |
| mclr_n | input | 1 | Asynchronous external master-clear, active low |
| rc_tick | input | 1 | One-clock enable per internal RC period |
| osc_tick | input | 1 | One-clock enable per oscillator period |
| osc_mode | input | 3 | Static oscillator mode: 0 PLL, 1 crystal, 2 ext clock, 3 RC, 4 internal |
| pm_wake | input | 1 | One-clock pulse on wake from a power-managed mode |
| hard_rst_evt | input | 1 | One-clock pulse for a core-originated hard reset |
| core_rst | output | 1 | Internal reset to the core, active high |
| cfg_reload | output | 1 | One-clock configuration reload request |
| stage | output | 3 | Current sequencer stage code |

## Verification
The bench builds the block with `PWRT_TICKS` = 8, `OST_CYCLES` = 5 and `PLL_TICKS` = 3 instead of 2048, 1024 and 62. With these values it can count every stage to its last tick and check the stage one tick before and at each boundary, in every oscillator mode. The short counts also leave room to abort the sequence partway through with POR, to let the power-up timer expire while master-clear is held low, and to wake in each mode class, all in a few thousand cycles.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

  typedef enum logic [2:0] {
    ST_PORW = 3'd0,
    ST_PWRT = 3'd1,
    ST_OST  = 3'd2,
    ST_PLL  = 3'd3,
    ST_RUN  = 3'd4
  } seq_stage_e;

  localparam logic [2:0] MODE_PLL  = 3'd0;
  localparam logic [2:0] MODE_XTAL = 3'd1;

  // Modes that need an oscillator settle count after power-up or wake
  function automatic logic mode_needs_ost(input logic [2:0] m);
    return (m == MODE_PLL) || (m == MODE_XTAL);
  endfunction

endpackage

// File: rtl/por_sync2.sv
module por_sync2 #(
  parameter int         WIDTH   = 2,
  parameter logic [1:0] RST_VAL = 2'b00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  // Per-bit reset value taken from RST_VAL
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[b] <= RST_VAL[b];
        sync_q[b] <= RST_VAL[b];
      end else begin
        meta_q[b] <= d_async[b];
        sync_q[b] <= meta_q[b];
      end
    end
  end

  assign q_sync = sync_q;

endmodule

// File: rtl/por_seq_fsm.sv
module por_seq_fsm
  import por_seq_pkg::*;
#(
  parameter int PWRT_TICKS = 2048,
  parameter int OST_CYCLES = 1024,
  parameter int PLL_TICKS  = 62
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_s,
  input  logic       rc_tick,
  input  logic       osc_tick,
  input  logic       pm_wake,
  input  logic [2:0] osc_mode,
  output logic [2:0] stage_o
);

  localparam int MAX_AB = (PWRT_TICKS > OST_CYCLES) ? PWRT_TICKS : OST_CYCLES;
  localparam int MAX_C  = (MAX_AB > PLL_TICKS) ? MAX_AB : PLL_TICKS;
  localparam int CNT_W  = (MAX_C > 1) ? $clog2(MAX_C) : 1;
  localparam logic [CNT_W-1:0] PWRT_LAST = CNT_W'(PWRT_TICKS - 1);
  localparam logic [CNT_W-1:0] OST_LAST  = CNT_W'(OST_CYCLES - 1);
  localparam logic [CNT_W-1:0] PLL_LAST  = CNT_W'(PLL_TICKS - 1);

  seq_stage_e       stage_q, stage_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    stage_n = stage_q;
    cnt_n   = cnt_q;
    if (por_s) begin
      stage_n = ST_PORW;
      cnt_n   = '0;
    end else begin
      case (stage_q)
        ST_PORW: begin
          stage_n = ST_PWRT;
          cnt_n   = '0;
        end
        ST_PWRT: if (rc_tick) begin
          if (cnt_q == PWRT_LAST) begin
            cnt_n   = '0;
            stage_n = mode_needs_ost(osc_mode) ? ST_OST : ST_RUN;
          end else begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end
        ST_OST: if (osc_tick) begin
          if (cnt_q == OST_LAST) begin
            cnt_n   = '0;
            stage_n = (osc_mode == MODE_PLL) ? ST_PLL : ST_RUN;
          end else begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end
        ST_PLL: if (rc_tick) begin
          if (cnt_q == PLL_LAST) begin
            cnt_n   = '0;
            stage_n = ST_RUN;
          end else begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end
        ST_RUN: if (pm_wake && mode_needs_ost(osc_mode)) begin
          stage_n = ST_OST;
          cnt_n   = '0;
        end
        default: begin
          stage_n = ST_PORW;
          cnt_n   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_PORW;
      cnt_q   <= '0;
    end else begin
      stage_q <= stage_n;
      cnt_q   <= cnt_n;
    end
  end

  assign stage_o = stage_q;

  assert_por_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    por_s |=> (stage_q == ST_PORW));

  assert_pwrt_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_PWRT && !rc_tick && !por_s) |=> (stage_q == ST_PWRT));

  assert_ost_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_OST && !osc_tick && !por_s) |=> (stage_q == ST_OST));

  assert_pll_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_PLL && !rc_tick && !por_s) |=> (stage_q == ST_PLL));

  assert_stage_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q <= ST_RUN);

endmodule

// File: rtl/por_seq_out.sv
module por_seq_out
  import por_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] stage_i,
  input  logic       por_s,
  input  logic       mclr_s,
  input  logic       hard_rst_evt,
  output logic       core_rst,
  output logic       cfg_reload
);

  logic por_d, mclr_d;
  logic core_rst_q, core_rst_n;
  logic reload_q, reload_n;

  always_comb begin
    core_rst_n = (stage_i != ST_RUN) || !mclr_s || hard_rst_evt;
    reload_n   = (por_s && !por_d) || (mclr_d && !mclr_s) || hard_rst_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_d      <= 1'b1;
      mclr_d     <= 1'b0;
      core_rst_q <= 1'b1;
      reload_q   <= 1'b0;
    end else begin
      por_d      <= por_s;
      mclr_d     <= mclr_s;
      core_rst_q <= core_rst_n;
      reload_q   <= reload_n;
    end
  end

  assign core_rst   = core_rst_q;
  assign cfg_reload = reload_q;

  assert_hold_in_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_i != ST_RUN) |=> core_rst);

  assert_reload_on_mclr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mclr_s) |=> cfg_reload);

  assert_reload_on_por_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_s) |=> cfg_reload);

  assert_hard_evt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst_evt |=> (core_rst && cfg_reload));

  assert_mclr_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mclr_s |=> core_rst);

endmodule

// File: rtl/por_timeout_seq.sv
module por_timeout_seq #(
  parameter int PWRT_TICKS = 2048,
  parameter int OST_CYCLES = 1024,
  parameter int PLL_TICKS  = 62
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_in,
  input  logic       mclr_n,
  input  logic       rc_tick,
  input  logic       osc_tick,
  input  logic [2:0] osc_mode,
  input  logic       pm_wake,
  input  logic       hard_rst_evt,
  output logic       core_rst,
  output logic       cfg_reload,
  output logic [2:0] stage
);

  logic [1:0] sync_q;
  logic       por_s, mclr_s;
  logic [2:0] stage_w;

  // Bit 0: POR (resets asserted), bit 1: master-clear (resets low = asserted)
  por_sync2 #(.WIDTH(2), .RST_VAL(2'b01)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({mclr_n, por_in}),
    .q_sync  (sync_q)
  );

  assign por_s  = sync_q[0];
  assign mclr_s = sync_q[1];

  por_seq_fsm #(
    .PWRT_TICKS(PWRT_TICKS),
    .OST_CYCLES(OST_CYCLES),
    .PLL_TICKS (PLL_TICKS)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .por_s   (por_s),
    .rc_tick (rc_tick),
    .osc_tick(osc_tick),
    .pm_wake (pm_wake),
    .osc_mode(osc_mode),
    .stage_o (stage_w)
  );

  por_seq_out u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .stage_i     (stage_w),
    .por_s       (por_s),
    .mclr_s      (mclr_s),
    .hard_rst_evt(hard_rst_evt),
    .core_rst    (core_rst),
    .cfg_reload  (cfg_reload)
  );

  assign stage = stage_w;

endmodule

// File: tb/sim_por_timeout_seq.sv
`timescale 1ns/1ps
module sim_por_timeout_seq;

  localparam int P = 8;
  localparam int O = 5;
  localparam int L = 3;

  logic clk = 1'b0;
  logic rst_n, por_in, mclr_n, rc_tick, osc_tick, pm_wake, hard_rst_evt;
  logic [2:0] osc_mode;
  logic core_rst, cfg_reload;
  logic [2:0] stage;

  int n_tests = 0;
  int n_fail  = 0;
  int rl_cnt  = 0;

  always #10 clk = ~clk;

  por_timeout_seq #(.PWRT_TICKS(P), .OST_CYCLES(O), .PLL_TICKS(L)) u0 (
    .clk(clk), .rst_n(rst_n), .por_in(por_in), .mclr_n(mclr_n),
    .rc_tick(rc_tick), .osc_tick(osc_tick), .osc_mode(osc_mode),
    .pm_wake(pm_wake), .hard_rst_evt(hard_rst_evt),
    .core_rst(core_rst), .cfg_reload(cfg_reload), .stage(stage)
  );

  always @(negedge clk) if (cfg_reload) rl_cnt++;

  // {mode, stage after power-up timer, stage after start-up count}
  localparam logic [8:0] VEC [6] = '{
    {3'd0, 3'd2, 3'd3},
    {3'd1, 3'd2, 3'd4},
    {3'd2, 3'd4, 3'd4},
    {3'd3, 3'd4, 3'd4},
    {3'd4, 3'd4, 3'd4},
    {3'd6, 3'd4, 3'd4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rc_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      rc_tick = 1'b1; @(negedge clk);
      rc_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic osc_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      osc_tick = 1'b1; @(negedge clk);
      osc_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic por_cycle();
    por_in = 1'b1; cyc(4);
    por_in = 1'b0; cyc(5);
  endtask

  task automatic wake();
    pm_wake = 1'b1; @(negedge clk);
    pm_wake = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; por_in = 1'b1; mclr_n = 1'b1; rc_tick = 1'b0; osc_tick = 1'b0;
    pm_wake = 1'b0; hard_rst_evt = 1'b0; osc_mode = 3'd2;
    cyc(3);
    chk(core_rst == 1'b1, "R1 core_rst", core_rst, 1);
    chk(cfg_reload == 1'b0, "R1 cfg_reload", cfg_reload, 0);
    chk(stage == 3'd0, "R1 stage", stage, 0);
    rst_n = 1'b1; cyc(2);

    // Table walk over oscillator modes
    for (int v = 0; v < 6; v++) begin
      logic [2:0] m, e1, e2;
      {m, e1, e2} = VEC[v];
      osc_mode = m;
      por_in = 1'b1; cyc(4);
      rc_ticks(3);
      chk(stage == 3'd0, "R2 held in POR wait", stage, 0);
      por_in = 1'b0; cyc(5);
      chk(stage == 3'd1, "R2 timer started", stage, 1);
      rc_ticks(P - 1);
      chk(stage == 3'd1, "R3 timer length", stage, 1);
      chk(core_rst == 1'b1, "R3 reset held", core_rst, 1);
      rc_ticks(1);
      chk(stage == e1, "R4/R6 after timer", stage, e1);
      if (e1 == 3'd2) begin
        osc_ticks(O - 1);
        chk(stage == 3'd2, "R4 start-up length", stage, 2);
        osc_ticks(1);
        chk(stage == e2, "R4 after start-up", stage, e2);
        if (e2 == 3'd3) begin
          rc_ticks(L - 1);
          chk(stage == 3'd3, "R5 lock length", stage, 3);
          rc_ticks(1);
          chk(stage == 3'd4, "R5 after lock", stage, 4);
        end
      end
      cyc(2);
      chk(core_rst == 1'b0, "R12 running releases", core_rst, 0);
    end

    // R7: timer expires under master-clear, then immediate release
    osc_mode = 3'd2;
    mclr_n = 1'b0;
    por_cycle();
    rc_ticks(P); cyc(2);
    chk(stage == 3'd4, "R7 timer ran under mclr", stage, 4);
    chk(core_rst == 1'b1, "R7 held by mclr", core_rst, 1);
    mclr_n = 1'b1; cyc(2);
    chk(core_rst == 1'b1, "R7 before release", core_rst, 1);
    cyc(1);
    chk(core_rst == 1'b0, "R7 released", core_rst, 0);

    // R10: reload strobes
    rl_cnt = 0; mclr_n = 1'b0; cyc(6);
    chk(rl_cnt == 1, "R10 mclr reload", rl_cnt, 1);
    mclr_n = 1'b1; cyc(4);
    rl_cnt = 0; por_in = 1'b1; cyc(6);
    chk(rl_cnt == 1, "R10 por reload", rl_cnt, 1);
    por_in = 1'b0; cyc(5); rc_ticks(P); cyc(2);

    // R11: core hard reset event
    hard_rst_evt = 1'b1; @(negedge clk); hard_rst_evt = 1'b0;
    chk(core_rst == 1'b1, "R11 reset pulse", core_rst, 1);
    chk(cfg_reload == 1'b1, "R11 reload pulse", cfg_reload, 1);
    cyc(1);
    chk(core_rst == 1'b0, "R11 reset one cycle", core_rst, 0);
    chk(cfg_reload == 1'b0, "R11 reload one cycle", cfg_reload, 0);

    // R9: wake with no-delay mode
    rl_cnt = 0; wake(); cyc(3);
    chk(stage == 3'd4, "R9 wake ignored stage", stage, 4);
    chk(core_rst == 1'b0, "R9 wake ignored reset", core_rst, 0);
    chk(rl_cnt == 0, "R10 no reload on wake", rl_cnt, 0);

    // R9: wake in crystal mode
    osc_mode = 3'd1; wake(); cyc(2);
    chk(stage == 3'd2, "R9 wake start-up", stage, 2);
    chk(core_rst == 1'b1, "R9 wake holds reset", core_rst, 1);
    osc_ticks(O);
    chk(stage == 3'd4, "R9 wake done", stage, 4);

    // R9: wake in PLL mode
    osc_mode = 3'd0; wake(); cyc(1);
    osc_ticks(O);
    chk(stage == 3'd3, "R9 wake lock wait", stage, 3);
    rc_ticks(L);
    chk(stage == 3'd4, "R9 wake lock done", stage, 4);

    // R8: abort in start-up and in timer
    osc_mode = 3'd1;
    por_cycle(); rc_ticks(P); osc_ticks(2);
    por_in = 1'b1; cyc(4);
    chk(stage == 3'd0, "R8 abort from start-up", stage, 0);
    chk(core_rst == 1'b1, "R8 abort reset", core_rst, 1);
    por_in = 1'b0; cyc(5);
    rc_ticks(3);
    por_in = 1'b1; cyc(4);
    chk(stage == 3'd0, "R8 abort from timer", stage, 0);
    por_in = 1'b0; cyc(5);
    rc_ticks(P - 1);
    chk(stage == 3'd1, "R8 counter cleared", stage, 1);
    rc_ticks(1);
    chk(stage == 3'd2, "R8 full count after abort", stage, 2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule